// File: doc/BRIEF.md
# Compare-Match Timer

This peripheral provides one or more timer channels behind a simple register bus. Each channel divides the system clock by a selectable ratio. It advances an up-counter on every divided tick, and compares the counter with a programmable compare value. When the two are equal on a tick, the counter restarts from zero, a sticky match flag is raised and, if the channel's interrupt enable is set, the shared interrupt line goes high. It stays high until software clears the flag.

A single start register, common to all channels, holds one run bit per channel. Software updates it with read-modify-write. A write to a channel's counter is not applied at once: it is parked and lands on the second divided tick after the write, much like a counter that lives in a slow clock domain. The register stride and the counter width follow a width parameter, with a 16-bit variant and a 32-bit variant.

Top module: `cmt_timer`

## Requirements
- R1: The start register at byte address 0 holds one run bit per channel (bit c for channel c) and reads back as written. Rewriting it with a channel's bit unchanged leaves that channel's counting undisturbed.
- R2: Channel c occupies byte addresses (c+1)*4*S upward, where S is 4 in the 32-bit variant and 2 in the 16-bit variant. Control/status is at offset 0, the counter at offset S and the compare register at offset 2*S. Any other address reads as zero.
- R3: Control/status is 16 bits wide and its upper bus bits read as zero. Bits [1:0] select the divider 8 << (2*sel), giving 8, 32, 128 or 512. The interrupt enable is bit 5 in the 32-bit variant and bit 6 in the 16-bit variant. Unassigned bits read as zero.
- R4: When a run bit goes from 0 to 1, the divider restarts, so the first count lands exactly one full divider period (8 clocks for sel 0) after the start write. After that the counter advances once per period.
- R5: A running counter that equals the compare value on a tick goes to zero, so the period is compare+1 ticks. After reset the compare register holds all ones and the counter holds zero. A new compare value is used from the next tick on.
- R6: The match flag (bit 15 in the 32-bit variant, bit 7 in the 16-bit variant) is set on the tick where the counter restarts from the compare value. It stays set until cleared.
- R7: Writing control/status with a flag bit at 0 clears that flag, and writing it at 1 leaves the flag unchanged. A flag that hardware sets in the same cycle as a clearing write ends up set.
- R8: In the 32-bit variant, a counter that passes all ones without matching wraps to zero and sets the wrap flag at bit 14. That flag clears the same way as the match flag.
- R9: A counter write leaves reads showing the old value until the second divider tick after the write. On that tick the written value replaces the counter. Counting goes on in the meantime.
- R10: The interrupt output is high while any channel has a set flag together with its interrupt enable. Writing zero to control/status drops it.
- R11: A channel whose run bit is 0 holds its counter value, unless a parked counter write lands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, OR of enabled flags |

## Verification
Register writes take effect at the clock edge that samples the strobe. Reads and the interrupt line follow the registered state with no further delay, so every sample is taken just after a falling edge, from the state the last rising edge produced. Counter advances and flags fall due a whole divider period after the start edge. The directed checks count exactly 7 and 8 edges, then 31 and 32 edges, from the start write, to catch the first count and the first match. A parked counter write must not be visible at the first falling edge after it and must be visible 16 edges later, the latest that two sel-0 ticks can arrive. The random phase compares every read and the interrupt line against a bench model that steps once per rising edge.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int SEL_W = 2;
    localparam int PS_W  = 9;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // last prescaler state for a divider of 8 << (2*sel)
    function automatic logic [PS_W-1:0] ps_last(input logic [SEL_W-1:0] sel);
        return PS_W'((8 << (2 * sel)) - 1);
    endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt >= ps_last(sel));
        if (restart || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wr_ctrl,
    input  logic             wr_cnt,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             flag_m_o,
    output logic             flag_w_o,
    output logic             pend_o,
    output logic             irq_o
);
    localparam bit WIDE   = (CNT_W > 16);
    localparam int FM_BIT = WIDE ? 15 : 7;
    localparam int FW_BIT = 14;
    localparam int IE_BIT = WIDE ? 5 : 6;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] pval;
        logic [SEL_W-1:0] sel;
        logic             ie;
        logic             fm;
        logic             fw;
        logic             pend;
        logic             pstep;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      hit_m, hit_w, keep_m, keep_w;

    always_comb begin
        s_d   = s_q;
        hit_m = 1'b0;
        hit_w = 1'b0;

        // count path, with the parked write landing on its second tick
        if (tick) begin
            if (s_q.pend && s_q.pstep) begin
                s_d.cnt   = s_q.pval;
                s_d.pend  = 1'b0;
                s_d.pstep = 1'b0;
            end else begin
                if (s_q.pend) begin
                    s_d.pstep = 1'b1;
                end
                if (run) begin
                    if (s_q.cnt == s_q.cmp) begin
                        s_d.cnt = '0;
                        hit_m   = 1'b1;
                    end else if (s_q.cnt == '1) begin
                        s_d.cnt = '0;
                        hit_w   = WIDE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
        end

        if (wr_cnt) begin
            s_d.pend  = 1'b1;
            s_d.pstep = 1'b0;
            s_d.pval  = wdata;
        end

        if (wr_cmp) begin
            s_d.cmp = wdata;
        end

        keep_m = wr_ctrl ? wdata[FM_BIT] : 1'b1;
        keep_w = wr_ctrl ? wdata[FW_BIT] : 1'b1;
        if (wr_ctrl) begin
            s_d.sel = wdata[SEL_W-1:0];
            s_d.ie  = wdata[IE_BIT];
        end
        // a hardware set outranks a clearing write in the same cycle
        s_d.fm = (s_q.fm & keep_m) | hit_m;
        s_d.fw = WIDE && ((s_q.fw & keep_w) | hit_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmp <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctrl_o              = '0;
        ctrl_o[SEL_W-1:0]   = s_q.sel;
        ctrl_o[IE_BIT]      = s_q.ie;
        ctrl_o[FM_BIT]      = s_q.fm;
        if (WIDE) begin
            ctrl_o[FW_BIT] = s_q.fw;
        end
    end

    assign cnt_o    = s_q.cnt;
    assign cmp_o    = s_q.cmp;
    assign sel_o    = s_q.sel;
    assign flag_m_o = s_q.fm;
    assign flag_w_o = s_q.fw;
    assign pend_o   = s_q.pend;
    assign irq_o    = s_q.ie & (s_q.fm | s_q.fw);
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter  int NCH    = 2,
    parameter  int CNT_W  = 32,
    localparam int STRIDE = (CNT_W > 16) ? 4 : 2,
    localparam int SPAN   = 4 * STRIDE,
    localparam int ADDR_W = $clog2((NCH + 1) * SPAN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic [NCH-1:0] run;
    } top_state_t;

    top_state_t s_d, s_q;

    logic                       wr_start;
    logic [NCH-1:0]             restart_v;
    logic [NCH-1:0]             tick_v;
    logic [NCH-1:0]             flag_m_v;
    logic [NCH-1:0]             flag_w_v;
    logic [NCH-1:0]             pend_v;
    logic [NCH-1:0]             irq_v;
    logic [NCH-1:0][REG_W-1:0]  ctrl_rd;
    logic [NCH-1:0][CNT_W-1:0]  cnt_rd;
    logic [NCH-1:0][CNT_W-1:0]  cmp_rd;
    reg_sel_e                   rsel_a [NCH];

    assign wr_start = bus_we && (bus_addr == '0);

    always_comb begin
        s_d = s_q;
        if (wr_start) begin
            s_d.run = bus_wdata[NCH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : gen_ch
        localparam int BASE = (c + 1) * SPAN;

        logic [ADDR_W-1:0] off;
        logic              in_rng;
        reg_sel_e          rsel;
        logic [SEL_W-1:0]  sel;

        assign off    = bus_addr - ADDR_W'(BASE);
        assign in_rng = (bus_addr >= ADDR_W'(BASE)) && (bus_addr < ADDR_W'(BASE + SPAN));

        always_comb begin
            rsel = SEL_NONE;
            if (in_rng) begin
                if (off == '0) begin
                    rsel = SEL_CTRL;
                end else if (off == ADDR_W'(STRIDE)) begin
                    rsel = SEL_CNT;
                end else if (off == ADDR_W'(2 * STRIDE)) begin
                    rsel = SEL_CMP;
                end
            end
        end

        assign rsel_a[c]    = rsel;
        assign restart_v[c] = wr_start && bus_wdata[c] && !s_q.run[c];

        cmt_prescaler i_ps (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart_v[c]),
            .sel     (sel),
            .tick    (tick_v[c])
        );

        cmt_channel #(.CNT_W(CNT_W)) i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (s_q.run[c]),
            .tick     (tick_v[c]),
            .wr_ctrl  (bus_we && (rsel == SEL_CTRL)),
            .wr_cnt   (bus_we && (rsel == SEL_CNT)),
            .wr_cmp   (bus_we && (rsel == SEL_CMP)),
            .wdata    (bus_wdata),
            .ctrl_o   (ctrl_rd[c]),
            .cnt_o    (cnt_rd[c]),
            .cmp_o    (cmp_rd[c]),
            .sel_o    (sel),
            .flag_m_o (flag_m_v[c]),
            .flag_w_o (flag_w_v[c]),
            .pend_o   (pend_v[c]),
            .irq_o    (irq_v[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) begin
            bus_rdata[NCH-1:0] = s_q.run;
        end
        for (int c = 0; c < NCH; c++) begin
            case (rsel_a[c])
                SEL_CTRL: bus_rdata = CNT_W'(ctrl_rd[c]);
                SEL_CNT:  bus_rdata = cnt_rd[c];
                SEL_CMP:  bus_rdata = cmp_rd[c];
                default:  ;
            endcase
        end
    end

    assign irq = |irq_v;
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
    parameter int NCH   = 2,
    parameter int CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            run_q,
    input logic [NCH-1:0]            tick_v,
    input logic [NCH-1:0]            restart_v,
    input logic [NCH-1:0]            pend_v,
    input logic [NCH-1:0]            flag_m_v,
    input logic [NCH-1:0]            flag_w_v,
    input logic [NCH-1:0][CNT_W-1:0] cnt_rd,
    input logic                      irq
);
    for (genvar c = 0; c < NCH; c++) begin : gen_chk
        // R11: stopped channel with no parked write keeps its count
        assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[c] && !pend_v[c]) |=> $stable(cnt_rd[c]));

        // R5: a match leaves the counter at zero
        assert_match_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_m_v[c]) |-> (cnt_rd[c] == '0));

        // R6: the match flag rises only from a running tick
        assert_flag_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_m_v[c]) |-> $past(tick_v[c] && run_q[c]));

        // R4: no tick in the cycle straight after a restart
        assert_first_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
            restart_v[c] |=> !tick_v[c]);

        // R8: a wrap leaves the counter at zero
        assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_w_v[c]) |-> (cnt_rd[c] == '0));
    end

    // R10: the interrupt needs a set flag somewhere
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(flag_m_v | flag_w_v)));
endmodule

bind cmt_timer cmt_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (s_q.run),
    .tick_v    (tick_v),
    .restart_v (restart_v),
    .pend_v    (pend_v),
    .flag_m_v  (flag_m_v),
    .flag_w_v  (flag_w_v),
    .cnt_rd    (cnt_rd),
    .irq       (irq)
);

// File: tb/test_cmt_timer.sv
`timescale 1ns/1ps
module test_cmt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cmt_timer i_cmt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // reference model built from the requirements (32-bit variant, 2 channels)
    logic [31:0] m_cnt [2];
    logic [31:0] m_cmp [2];
    logic [31:0] m_pval [2];
    int          m_ps [2];
    logic [1:0]  m_sel [2];
    logic        m_ie [2], m_fm [2], m_fw [2], m_pend [2], m_pst [2];
    logic [1:0]  m_run;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = '0;
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = '0; m_cmp[c] = '1; m_pval[c] = '0; m_ps[c] = 0;
                m_sel[c] = '0; m_ie[c] = 0; m_fm[c] = 0; m_fw[c] = 0;
                m_pend[c] = 0; m_pst[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit tk, rs, wc, wn, wp, hm, hw;
                tk = m_ps[c] >= ((8 << (2 * m_sel[c])) - 1);
                rs = bus_we && bus_addr == 0 && bus_wdata[c] && !m_run[c];
                wc = bus_we && bus_addr == 6'((c + 1) * 16);
                wn = bus_we && bus_addr == 6'((c + 1) * 16 + 4);
                wp = bus_we && bus_addr == 6'((c + 1) * 16 + 8);
                hm = 0; hw = 0;
                m_ps[c] = (rs || tk) ? 0 : m_ps[c] + 1;
                if (tk) begin
                    if (m_pend[c] && m_pst[c]) begin
                        m_cnt[c] = m_pval[c]; m_pend[c] = 0; m_pst[c] = 0;
                    end else begin
                        if (m_pend[c]) m_pst[c] = 1;
                        if (m_run[c]) begin
                            if (m_cnt[c] == m_cmp[c]) begin m_cnt[c] = 0; hm = 1; end
                            else if (m_cnt[c] == 32'hFFFF_FFFF) begin m_cnt[c] = 0; hw = 1; end
                            else m_cnt[c] = m_cnt[c] + 1;
                        end
                    end
                end
                if (wn) begin m_pend[c] = 1; m_pst[c] = 0; m_pval[c] = bus_wdata; end
                if (wp) m_cmp[c] = bus_wdata;
                m_fm[c] = (m_fm[c] & (wc ? bus_wdata[15] : 1'b1)) | hm;
                m_fw[c] = (m_fw[c] & (wc ? bus_wdata[14] : 1'b1)) | hw;
                if (wc) begin m_sel[c] = bus_wdata[1:0]; m_ie[c] = bus_wdata[5]; end
            end
            if (bus_we && bus_addr == 0) m_run = bus_wdata[1:0];
        end
    end

    function automatic logic [31:0] mread(input logic [5:0] a);
        if (a == 0) return {30'b0, m_run};
        for (int c = 0; c < 2; c++) begin
            if (a == 6'((c + 1) * 16))
                return {16'b0, m_fm[c], m_fw[c], 8'b0, m_ie[c], 3'b0, m_sel[c]};
            if (a == 6'((c + 1) * 16 + 4)) return m_cnt[c];
            if (a == 6'((c + 1) * 16 + 8)) return m_cmp[c];
        end
        return '0;
    endfunction

    function automatic logic m_irq();
        return (m_ie[0] & (m_fm[0] | m_fw[0])) | (m_ie[1] & (m_fm[1] | m_fw[1]));
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdv(input logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, v0;
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rdv(0, v);  chk("R1 start after reset", v, 0);
        rdv(16, v); chk("R3 ctrl after reset", v, 0);
        rdv(20, v); chk("R5 count after reset", v, 0);
        rdv(24, v); chk("R5 compare after reset", v, 32'hFFFF_FFFF);
        rdv(4, v);  chk("R2 unmapped address", v, 0);
        chk("R10 irq after reset", {31'b0, irq}, 0);

        // first count and first match, sel 0, compare 3
        wr(24, 3);
        wr(16, 32'h0000_0020);
        wr(0, 1);
        repeat (7) @(negedge clk);
        rdv(20, v); chk("R4 no count before one period", v, 0);
        @(negedge clk);
        rdv(20, v); chk("R4 first count after one period", v, 1);
        repeat (23) @(negedge clk);
        rdv(20, v); chk("R5 count at compare", v, 3);
        chk("R10 irq before match", {31'b0, irq}, 0);
        @(negedge clk);
        rdv(20, v); chk("R5 restart from zero", v, 0);
        rdv(16, v); chk("R6 match flag bit 15", v, 32'h0000_8020);
        chk("R10 irq on match", {31'b0, irq}, 1);

        // flag clearing
        wr(0, 0);
        wr(16, 32'h0000_8020);
        rdv(16, v); chk("R7 writing one keeps flag", v, 32'h0000_8020);
        chk("R10 irq still high", {31'b0, irq}, 1);
        wr(16, 32'h0000_0020);
        rdv(16, v); chk("R7 writing zero clears flag", v, 32'h0000_0020);
        chk("R10 irq low after clear", {31'b0, irq}, 0);

        // stopped channel holds, other channel independent
        rdv(20, v0);
        repeat (40) @(negedge clk);
        rdv(20, v); chk("R11 stopped counter holds", v, v0);
        wr(0, 2);
        rdv(0, v); chk("R1 start readback", v, 2);
        repeat (20) @(negedge clk);
        rdv(20, v); chk("R1 channel 0 undisturbed", v, v0);
        rdv(36, v); chk("R4 channel 1 two periods", v, 2);

        // delayed counter write
        wr(20, 100);
        rdv(20, v); chk("R9 old value before landing", v, v0);
        repeat (16) @(negedge clk);
        rdv(20, v); chk("R9 written value after two ticks", v, 100);

        // wrap past all ones
        wr(24, 5);
        wr(20, 32'hFFFF_FFFE);
        repeat (16) @(negedge clk);
        wr(0, 3);
        repeat (30) @(negedge clk);
        rdv(16, v); chk("R8 wrap flag bit 14", v, 32'h0000_4020);
        rdv(20, v); chk("R8 count after wrap", v, 1);
        chk("R10 irq on wrap", {31'b0, irq}, 1);
        wr(16, 0);
        rdv(16, v); chk("R10 ctrl zero", v, 0);
        chk("R10 irq dropped by zero write", {31'b0, irq}, 0);
        wr(16, 32'hFFFF_FFFF);
        rdv(16, v); chk("R3 ctrl field mask", v, 32'h0000_0023);

        // random phase against the model
        for (int it = 0; it < 3000; it++) begin
            int op, ch, base;
            logic [31:0] d;
            op = $urandom_range(0, 9);
            ch = $urandom_range(0, 1);
            base = (ch + 1) * 16;
            if (op < 4) begin
                int r;
                logic [5:0] a;
                r = $urandom_range(0, 4);
                a = (r == 0) ? 6'd0 : (r == 4) ? 6'(base + 12) : 6'(base + (r - 1) * 4);
                rdv(a, v);
                case (r)
                    0: chk("R1 random start read", v, mread(a));
                    1: chk("R7 random ctrl read", v, mread(a));
                    2: chk("R9 random count read", v, mread(a));
                    3: chk("R5 random compare read", v, mread(a));
                    default: chk("R2 random unmapped read", v, mread(a));
                endcase
            end else if (op < 7) begin
                case ($urandom_range(0, 3))
                    0: wr(0, $urandom_range(0, 3));
                    1: begin
                        d = $urandom & 32'h0000_C020;
                        if ($urandom_range(0, 3) == 0) d[1:0] = 2'($urandom_range(0, 3));
                        wr(6'(base), d);
                    end
                    2: begin
                        d = $urandom_range(0, 1) ? $urandom_range(0, 30)
                                                 : 32'hFFFF_FFF0 + $urandom_range(0, 15);
                        wr(6'(base + 4), d);
                    end
                    default: begin
                        d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom_range(0, 30);
                        wr(6'(base + 8), d);
                    end
                endcase
                #1;
            end else begin
                repeat ($urandom_range(1, 20)) @(negedge clk);
                #1;
            end
            chk("R10 random irq", {31'b0, irq}, {31'b0, m_irq()});
        end

        finish_run();
    end
endmodule